// File: doc/BRIEF.md
# Sequential Shift and Rotate Unit

This block moves the bits of an 8-bit or 16-bit operand left or right, one bit position per clock, in one of seven shift and rotate modes. The step count is either the fixed value 1 or an 8-bit count value taken from a count input. When the last step is done, the block updates a carry flag with the last bit that left the operand. It also updates an overflow flag, and for shifts the sign, zero and parity flags. It then raises `done` for one cycle.

A caller pulses `start` while the unit is idle, with the operand, width, mode, count source, count and carry input all valid in that cycle. The control machine has three named states. IDLE waits for `start`. RUN performs one step per clock. FINISH presents `done` for one cycle. The transitions are IDLE to RUN (start with a non-zero count), IDLE to FINISH (start with a zero count), RUN to RUN (more than one step left), RUN to FINISH (the last step is taken in this clock) and FINISH to IDLE (always). `result` and the flags hold their values until the next operation writes them.

Top module: `shift_rotate_unit`

## Requirements
- R1: After reset, `result` is 0, all five flags are 0, and `done` and `busy` are 0.
- R2: The effective count is 1 when `use_reg` is 0 and `cnt_reg` when `use_reg` is 1. For a count N of 1 or more, `done` is high for exactly one cycle, N clock edges after the edge that samples `start`. `busy` is high from the edge after that sample through the `done` cycle.
- R3: A zero effective count makes `done` rise on the edge after `start`. `result` then equals the operand (low byte only in byte mode), and none of the five flags change.
- R4: Mode 0 (logical left) and mode 7 (its alias) shift left and insert 0 at bit 0. The top bit moves to CF.
- R5: Mode 1 (logical right) shifts right and inserts 0 at the top bit. Bit 0 moves to CF.
- R6: Mode 2 (arithmetic right) shifts right and keeps the old top bit in the top position. Bit 0 moves to CF.
- R7: Mode 3 (rotate left) moves the top bit to bit 0. Mode 4 (rotate right) moves bit 0 to the top bit. CF receives the bit that moved.
- R8: Mode 5 (left through carry) and mode 6 (right through carry) rotate through a carry bit that starts at `carry_in`. The outgoing bit becomes the new carry, and the previous carry enters the vacated end.
- R9: After a non-zero count, CF equals the last bit shifted out of the operand.
- R10: With a count of exactly 1, OF is set as follows. For left modes (0, 3, 5, 7), OF is the result top bit XOR the new CF. For right modes (1, 2, 4, 6), OF is the original top bit XOR the result top bit. With a count above 1, OF keeps its previous value.
- R11: Shift modes (0, 1, 2, 7) set SF to the result top bit, ZF when the result is zero, and PF when the low 8 bits of the result hold an even number of ones. Rotate modes (3 to 6) leave SF, ZF and PF unchanged.
- R12: With `wide` at 0 the operation uses only bits 7..0, and bit 7 is the top bit. `result[15:8]` reads 0 while the operation runs and after it completes.
- R13: A `start` pulse while `busy` is high is ignored. It changes neither the result, nor the flags, nor the timing of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| operand | input | 16 | Value to shift or rotate |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| mode | input | 3 | Shift or rotate mode, 0..7 |
| use_reg | input | 1 | 1 = take count from `cnt_reg`, 0 = count of 1 |
| cnt_reg | input | 8 | Count value |
| carry_in | input | 1 | Initial carry for the through-carry rotates |
| result | output | 16 | Operand after the operation |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
The bench drives every mode in both widths and compares each result with a bit-serial reference. Several bugs show up as wrong bits in the result: treating bit 15 as the top bit in byte mode leaks bits into the upper byte, an arithmetic right shift that fills with 0 turns negative values positive, and a through-carry rotate that ignores `carry_in` puts the wrong bit at the vacated end. The bench also hunts timing and flag faults. A zero count that is run as a long loop, or that writes the flags, changes `done` timing or flag state, and an off-by-one step counter moves `done` by a cycle. Beyond that, rotates that touch SF, ZF or PF, an OF written for counts above one, and a second `start` accepted mid-operation each leave a flag or result different from the reference.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;

    typedef enum logic [2:0] {
        MD_SHL  = 3'd0,
        MD_SHR  = 3'd1,
        MD_SAR  = 3'd2,
        MD_ROL  = 3'd3,
        MD_ROR  = 3'd4,
        MD_RCL  = 3'd5,
        MD_RCR  = 3'd6,
        MD_SHLA = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } state_e;

    function automatic logic is_left(input mode_e m);
        return (m == MD_SHL) || (m == MD_SHLA) || (m == MD_ROL) || (m == MD_RCL);
    endfunction

    function automatic logic is_shift(input mode_e m);
        return (m == MD_SHL) || (m == MD_SHLA) || (m == MD_SHR) || (m == MD_SAR);
    endfunction

endpackage

// File: rtl/shift_rotate_step.sv
module shift_rotate_step
    import shift_rotate_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic [DW-1:0] cur,
    input  logic          wide,
    input  mode_e         mode,
    input  logic          cin,
    output logic [DW-1:0] nxt,
    output logic          cout
);
    localparam logic [DW-1:0] LOW_MASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};

    logic          top_bit;
    logic          fill;
    logic          to_left;
    logic [DW-1:0] raw;

    always_comb begin
        top_bit = wide ? cur[DW-1] : cur[BW-1];
        fill    = 1'b0;
        to_left = 1'b1;
        cout    = top_bit;
        unique case (mode)
            MD_SHL, MD_SHLA: begin fill = 1'b0;    to_left = 1'b1; cout = top_bit; end
            MD_ROL:          begin fill = top_bit; to_left = 1'b1; cout = top_bit; end
            MD_RCL:          begin fill = cin;     to_left = 1'b1; cout = top_bit; end
            MD_SHR:          begin fill = 1'b0;    to_left = 1'b0; cout = cur[0];  end
            MD_SAR:          begin fill = top_bit; to_left = 1'b0; cout = cur[0];  end
            MD_ROR:          begin fill = cur[0];  to_left = 1'b0; cout = cur[0];  end
            MD_RCR:          begin fill = cin;     to_left = 1'b0; cout = cur[0];  end
        endcase

        if (to_left) begin
            raw = {cur[DW-2:0], fill};
        end else begin
            raw = cur >> 1;
            if (wide) raw[DW-1] = fill;
            else      raw[BW-1] = fill;
        end
        nxt = wide ? raw : (raw & LOW_MASK);
    end
endmodule

// File: rtl/shift_rotate_flags.sv
module shift_rotate_flags #(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic [DW-1:0] val,
    input  logic          wide,
    output logic          sign,
    output logic          zero,
    output logic          parity
);
    logic [BW-1:0] ones_vec;

    for (genvar g = 0; g < BW; g++) begin : g_par
        if (g == 0) begin : g_first
            assign ones_vec[g] = val[g];
        end else begin : g_chain
            assign ones_vec[g] = ones_vec[g-1] ^ val[g];
        end
    end

    always_comb begin
        sign   = wide ? val[DW-1] : val[BW-1];
        zero   = (val == '0);
        parity = ~ones_vec[BW-1];
    end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import shift_rotate_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] operand,
    input  logic          wide,
    input  logic [2:0]    mode,
    input  logic          use_reg,
    input  logic [CW-1:0] cnt_reg,
    input  logic          carry_in,
    output logic [DW-1:0] result,
    output logic          cf,
    output logic          of,
    output logic          sf,
    output logic          zf,
    output logic          pf,
    output logic          done,
    output logic          busy
);
    localparam logic [DW-1:0] LOW_MASK = {{(DW-BW){1'b0}}, {BW{1'b1}}};
    localparam logic [CW-1:0] ONE_CNT  = CW'(1);

    state_e        state_q, state_d;
    logic [DW-1:0] work_q;
    logic          carry_q;
    logic [CW-1:0] cnt_q;
    mode_e         mode_q;
    logic          wide_q;
    logic          orig_top_q;
    logic          single_q;
    logic          cf_q, of_q, sf_q, zf_q, pf_q;

    logic [CW-1:0] eff_cnt;
    logic          accept;
    logic          last_step;
    logic [DW-1:0] step_val;
    logic          step_out;
    logic          new_sign, new_zero, new_par;
    logic          new_top;

    assign eff_cnt   = use_reg ? cnt_reg : ONE_CNT;
    assign accept    = (state_q == ST_IDLE) && start;
    assign last_step = (state_q == ST_RUN) && (cnt_q == ONE_CNT);
    assign new_top   = wide_q ? step_val[DW-1] : step_val[BW-1];

    shift_rotate_step #(.DW(DW), .BW(BW)) u_step (
        .cur  (work_q),
        .wide (wide_q),
        .mode (mode_q),
        .cin  (carry_q),
        .nxt  (step_val),
        .cout (step_out)
    );

    shift_rotate_flags #(.DW(DW), .BW(BW)) u_flags (
        .val    (step_val),
        .wide   (wide_q),
        .sign   (new_sign),
        .zero   (new_zero),
        .parity (new_par)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (eff_cnt == '0) ? ST_FINISH : ST_RUN;
            ST_RUN:    if (cnt_q == ONE_CNT) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q     <= '0;
            carry_q    <= 1'b0;
            cnt_q      <= '0;
            mode_q     <= MD_SHL;
            wide_q     <= 1'b0;
            orig_top_q <= 1'b0;
            single_q   <= 1'b0;
            cf_q       <= 1'b0;
            of_q       <= 1'b0;
            sf_q       <= 1'b0;
            zf_q       <= 1'b0;
            pf_q       <= 1'b0;
        end else if (accept) begin
            work_q     <= wide ? operand : (operand & LOW_MASK);
            carry_q    <= carry_in;
            cnt_q      <= eff_cnt;
            mode_q     <= mode_e'(mode);
            wide_q     <= wide;
            orig_top_q <= wide ? operand[DW-1] : operand[BW-1];
            single_q   <= (eff_cnt == ONE_CNT);
        end else if (state_q == ST_RUN) begin
            work_q  <= step_val;
            carry_q <= step_out;
            cnt_q   <= cnt_q - ONE_CNT;
            if (last_step) begin
                cf_q <= step_out;
                if (single_q) begin
                    if (is_left(mode_q)) of_q <= new_top ^ step_out;
                    else                 of_q <= orig_top_q ^ new_top;
                end
                if (is_shift(mode_q)) begin
                    sf_q <= new_sign;
                    zf_q <= new_zero;
                    pf_q <= new_par;
                end
            end
        end
    end

    // outputs
    always_comb begin
        done   = (state_q == ST_FINISH);
        busy   = (state_q != ST_IDLE);
        result = work_q;
        cf     = cf_q;
        of     = of_q;
        sf     = sf_q;
        zf     = zf_q;
        pf     = pf_q;
    end
endmodule

// File: rtl/shift_rotate_chk.sv
module shift_rotate_chk #(
    parameter int DW = 16,
    parameter int BW = 8,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          use_reg,
    input logic [CW-1:0] cnt_reg,
    input logic [DW-1:0] result,
    input logic          sf,
    input logic          zf,
    input logic          pf,
    input logic          done,
    input logic          busy,
    input logic          wide_q
);
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_zero_count_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && use_reg && (cnt_reg == '0)) |=> done);

    p_flags_settle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((sf != $past(sf)) || (zf != $past(zf)) || (pf != $past(pf))) |-> done);

    p_result_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> busy);

    p_byte_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wide_q) |-> (result[DW-1:BW] == '0));
endmodule

bind shift_rotate_unit shift_rotate_chk #(.DW(DW), .BW(BW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .use_reg (use_reg),
    .cnt_reg (cnt_reg),
    .result  (result),
    .sf      (sf),
    .zf      (zf),
    .pf      (pf),
    .done    (done),
    .busy    (busy),
    .wide_q  (wide_q)
);

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] operand = '0;
    logic        wide = 1'b0;
    logic [2:0]  mode = '0;
    logic        use_reg = 1'b0;
    logic [7:0]  cnt_reg = '0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        cf, of, sf, zf, pf, done, busy;

    int checks = 0;
    int errors = 0;

    // model flag state
    logic m_cf = 0, m_of = 0, m_sf = 0, m_zf = 0, m_pf = 0;

    always #4 clk = ~clk;

    shift_rotate_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand), .wide(wide),
        .mode(mode), .use_reg(use_reg), .cnt_reg(cnt_reg), .carry_in(carry_in),
        .result(result), .cf(cf), .of(of), .sf(sf), .zf(zf), .pf(pf),
        .done(done), .busy(busy)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // reference: one bit per step, written from the requirements
    task automatic model(input logic [15:0] op, input logic w, input logic [2:0] md,
                         input int n, input logic cin, output logic [15:0] res);
        int   tp;
        logic c, orig, lft, shf, outb;
        tp   = w ? 15 : 7;
        res  = w ? op : {8'h00, op[7:0]};
        orig = res[tp];
        c    = cin;
        lft  = (md == 0) || (md == 7) || (md == 3) || (md == 5);
        shf  = (md == 0) || (md == 7) || (md == 1) || (md == 2);
        if (n == 0) return;
        outb = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic hi, lo, fb;
            hi = res[tp];
            lo = res[0];
            case (md)
                3'd1:    fb = 1'b0;
                3'd2:    fb = hi;
                3'd3:    fb = hi;
                3'd4:    fb = lo;
                3'd5:    fb = c;
                3'd6:    fb = c;
                default: fb = 1'b0;
            endcase
            if (lft) begin
                outb = hi;
                res  = res << 1;
                res[0] = fb;
            end else begin
                outb = lo;
                res  = res >> 1;
                res[tp] = fb;
            end
            if (!w) res[15:8] = 8'h00;
            c = outb;
        end
        m_cf = outb;
        if (n == 1) m_of = lft ? (res[tp] ^ outb) : (orig ^ res[tp]);
        if (shf) begin
            m_sf = res[tp];
            m_zf = (res == 16'h0);
            m_pf = ~^res[7:0];
        end
    endtask

    task automatic check_flags(input string tag);
        chk(tag, "cf", cf, m_cf);
        chk(tag, "of", of, m_of);
        chk(tag, "sf", sf, m_sf);
        chk(tag, "zf", zf, m_zf);
        chk(tag, "pf", pf, m_pf);
    endtask

    task automatic run_op(input string tag, input logic [15:0] op, input logic w, input logic [2:0] md,
                          input logic ur, input logic [7:0] cnt, input logic cin);
        logic [15:0] exp_res;
        int n, edges;
        n = ur ? int'(cnt) : 1;
        model(op, w, md, n, cin, exp_res);
        @(negedge clk);
        operand = op; wide = w; mode = md; use_reg = ur; cnt_reg = cnt; carry_in = cin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        operand = ~op; carry_in = ~cin;
        edges = 0;
        while (!done && edges < 400) begin
            @(negedge clk);
            edges++;
        end
        chk(tag, "done edges", edges, n);
        chk(tag, "result", result, exp_res);
        check_flags(tag);
        @(negedge clk);
        chk(tag, "done one cycle", done, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1", "result", result, 16'h0);
        chk("R1", "done", done, 0);
        chk("R1", "busy", busy, 0);
        check_flags("R1");
    endtask

    task automatic t_modes;
        run_op("R4", 16'h8001, 1, 3'd0, 0, 8'd0, 0);
        run_op("R4", 16'h00C3, 0, 3'd7, 1, 8'd3, 0);
        run_op("R5", 16'h8001, 1, 3'd1, 0, 8'd0, 0);
        run_op("R5", 16'h0081, 0, 3'd1, 1, 8'd4, 0);
        run_op("R6", 16'h8004, 1, 3'd2, 1, 8'd3, 0);
        run_op("R6", 16'h0090, 0, 3'd2, 0, 8'd0, 0);
        run_op("R7", 16'h8001, 1, 3'd3, 1, 8'd5, 0);
        run_op("R7", 16'h0001, 0, 3'd4, 0, 8'd0, 1);
        run_op("R8", 16'h4000, 1, 3'd5, 0, 8'd0, 1);
        run_op("R8", 16'h0002, 0, 3'd6, 1, 8'd2, 1);
        run_op("R8", 16'h1234, 1, 3'd6, 1, 8'd17, 0);
        run_op("R9", 16'h0100, 1, 3'd1, 1, 8'd9, 0);
        run_op("R10", 16'h4000, 1, 3'd0, 0, 8'd0, 0);
        run_op("R10", 16'h0080, 0, 3'd1, 1, 8'd1, 0);
        run_op("R10", 16'h0040, 0, 3'd0, 1, 8'd2, 0);
        run_op("R11", 16'h00FF, 0, 3'd0, 1, 8'd8, 0);
        run_op("R11", 16'h0F0F, 1, 3'd3, 1, 8'd4, 0);
        run_op("R12", 16'hABFF, 0, 3'd3, 1, 8'd1, 0);
        run_op("R2", 16'h5A5A, 1, 3'd4, 1, 8'd255, 0);
    endtask

    task automatic t_zero;
        run_op("R10", 16'h4000, 1, 3'd0, 0, 8'd0, 0);
        run_op("R3", 16'hBEEF, 1, 3'd1, 1, 8'd0, 1);
        run_op("R3", 16'hBEEF, 0, 3'd5, 1, 8'd0, 1);
    endtask

    task automatic t_busy_ignore;
        logic [15:0] exp_res;
        int edges;
        model(16'h1357, 1, 3'd0, 6, 0, exp_res);
        @(negedge clk);
        operand = 16'h1357; wide = 1; mode = 3'd0; use_reg = 1; cnt_reg = 8'd6; carry_in = 0; start = 1;
        @(negedge clk);
        start = 0;
        @(negedge clk);
        operand = 16'hFFFF; mode = 3'd2; cnt_reg = 8'd1; start = 1;
        @(negedge clk);
        start = 0;
        edges = 2;
        while (!done && edges < 100) begin
            @(negedge clk);
            edges++;
        end
        chk("R13", "done edges", edges, 6);
        chk("R13", "result", result, exp_res);
        check_flags("R13");
        @(negedge clk);
        chk("R13", "idle after", busy, 0);
    endtask

    task automatic t_random;
        for (int k = 0; k < 160; k++) begin
            run_op("R2", 16'($urandom), 1'($urandom), 3'($urandom), 1'($urandom),
                   8'($urandom_range(0, 40)), 1'($urandom));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_zero();
        t_busy_ignore();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule